// File: doc/BRIEF.md
# UART Host Register Block with Transmit and Receive FIFOs

This block is the software-facing half of a 16450/16550-class serial port. A host reaches eight byte-wide locations through a 3-bit address with separate read and write strobes; the block keeps the line, modem, interrupt-enable, FIFO and scratch settings, the 16-bit baud divisor, and the line- and modem-status state. A bit-level shifter, which is a separate block, sits on the other side. It takes transmit bytes from the head of the transmit FIFO with a pop strobe. It hands in received bytes, each with its parity, framing and break flags, through a push strobe.

Both FIFOs are 16 deep in FIFO mode and act as one-byte holding registers otherwise. The error flags of a received byte travel with it through the receive FIFO. They reach the line status only once that byte is at the head, so software sees an error when the failing byte is next to be read. Status bits that latch errors or modem changes clear on the read that returns them. The divisor, line, modem-control, enable and FIFO-trigger settings are driven out to the neighbouring shifter, baud and interrupt blocks.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the line-control register reads 0x03, line status reads 0x60, offset 2 reads 0x01, and interrupt enable, scratch, modem status and the divisor are all zero.
- R2: While line-control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes. They leave the transmit FIFO and interrupt enable untouched. While bit 7 is 0, the same offsets are the data port and interrupt enable.
- R3: Written values are masked: interrupt enable keeps bits 3:0, modem control keeps bits 4:0, and FIFO control keeps bit 0 (FIFO enable) and bits 7:6 (receive trigger). Modem control at offset 4 always reads 0. Scratch at offset 7 keeps all 8 bits. Offset 2 reads {fifo_en, fifo_en, 6'b000001}.
- R4: The transmit FIFO delivers bytes in write order. It holds 16 entries when FIFO control bit 0 is 1 and 1 entry when it is 0. tx_valid_o and tx_data_o show its head, and tx_pop removes it.
- R5: A data-port write while the transmit FIFO is full replaces the entry at the write pointer and leaves the fill level unchanged. That entry is the current head.
- R6: Line status bit 5 is 1 exactly when the transmit FIFO is empty. Bit 6 is 1 when it is empty and tx_idle is 1. A data-port write clears both.
- R7: A FIFO-control write that changes bit 0 empties both FIFOs. Otherwise, bit 1 empties the receive FIFO (data-ready falls) and bit 2 empties the transmit FIFO (bit 5 rises). A write with neither bit set and an unchanged mode keeps the contents.
- R8: A data-port read returns and removes the oldest received byte, or returns 0 when the FIFO is empty. Line status bit 0 (data ready) is 1 exactly when received entries remain.
- R9: A push into a full receive FIFO is dropped, the stored entries stay intact, and line status bits 1 (overrun) and 7 (error summary) are set.
- R10: A received entry's flags, parity to bit 2, framing to bit 3 and break to bit 4 (plus bit 7 when any is set), enter line status only after the entry becomes the FIFO head. They are then removed from the entry, and its data byte is unaffected.
- R11: Reading line status at offset 5 returns its value and then clears bits 1, 2, 3, 4 and 7. Bits 0, 5 and 6 are unaffected, and host writes to offset 5 have no effect.
- R12: Modem status at offset 6 accumulates the bits pulsed on msr_set. Reading it returns the value and then clears all 8 bits, and host writes to offset 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Host register offset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (side effects take place at the clock edge) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the addressed offset |
| tx_valid_o | output | 1 | Transmit FIFO holds a byte |
| tx_data_o | output | 8 | Byte at the transmit FIFO head |
| tx_pop | input | 1 | Shifter takes the head byte |
| tx_idle | input | 1 | Shifter has nothing in flight |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | {break, framing, parity} flags of the received byte |
| msr_set | input | 8 | Modem-status bits to set this cycle |
| lcr_o | output | 8 | Line-control setting |
| ier_o | output | 4 | Interrupt-enable setting |
| mcr_o | output | 5 | Modem-control setting |
| divisor_o | output | 16 | Baud divisor {high, low} |
| fifo_en_o | output | 1 | FIFO mode active |
| rx_trig_o | output | 2 | Receive trigger-level code |

## Verification
The bench fills the transmit FIFO to all 16 entries and writes once more. A design that advanced the pointer or counter there would corrupt the order or lose the head replacement. A design that dropped the write would leave the old head in place. It places an errored byte behind a clean one, so a design that folded flags into line status at push time rather than at the head would show the error one read early. A design that did not scrub the entry would show it again after the status read. It overflows the one-entry receive buffer, which catches a design that lets the extra byte replace the stored one or forgets data-ready. It also checks that same-mode FIFO-control writes keep contents while a mode change flushes both sides, which catches a design that flushed on every control write. Seeded random interleaving of host and shifter traffic then checks ordering against reference queues.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int unsigned ERR_W = 4;   // {summary, break, framing, parity}

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IER  = 3'd1;
    localparam logic [2:0] OFS_FIFO = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_MCR  = 3'd4;
    localparam logic [2:0] OFS_LSR  = 3'd5;
    localparam logic [2:0] OFS_MSR  = 3'd6;
    localparam logic [2:0] OFS_SCR  = 3'd7;

    localparam logic [7:0] LCR_RESET = 8'h03;

    typedef struct packed {
        logic [7:0] lcr;
        logic [3:0] ier;
        logic [4:0] mcr;
        logic       fifo_en;
        logic [1:0] trig;
        logic [7:0] scr;
        logic [7:0] dll;
        logic [7:0] dlh;
        logic [7:0] msr;
        logic       err_oe;
        logic       err_pe;
        logic       err_fe;
        logic       err_bi;
        logic       err_sum;
    } regs_t;

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
    parameter  int unsigned W         = 8,
    parameter  int unsigned DEPTH     = 16,
    parameter  int unsigned KEEP_LO   = W,
    parameter  bit          DROP_FULL = 1'b0,
    localparam int unsigned AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          deep,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic          scrub,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);

    localparam logic [W-1:0] KEEP_MASK = ~({W{1'b1}} << KEEP_LO);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [LW-1:0] cnt;
    } ptr_t;

    ptr_t          q, d;
    logic [W-1:0]  mem [DEPTH];
    logic [LW-1:0] lim;
    logic          do_pop, adv, ovw, wr_slot;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [LW-1:0] l);
        return ({1'b0, p} == l - LW'(1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        lim     = deep ? LW'(DEPTH) : LW'(1);
        empty   = (q.cnt == '0);
        full    = (q.cnt == lim);
        do_pop  = pop & ~empty;
        adv     = push & (~full | do_pop);
        ovw     = push & full & ~do_pop & ~DROP_FULL;
        wr_slot = ~clr & (adv | ovw);
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (adv)    d.wptr = bump(q.wptr, lim);
            if (do_pop) d.rptr = bump(q.rptr, lim);
            d.cnt = q.cnt + LW'(adv) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (scrub && !empty) mem[q.rptr] <= mem[q.rptr] & KEEP_MASK;
        if (wr_slot)         mem[q.wptr] <= din;
    end

    assign head  = mem[q.rptr];
    assign level = q.cnt;

endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux (
    input  logic [2:0] addr,
    input  logic       dlab,
    input  logic [7:0] rbr,
    input  logic [7:0] dll,
    input  logic [7:0] dlh,
    input  logic [3:0] ier,
    input  logic [7:0] iir,
    input  logic [7:0] lcr,
    input  logic [7:0] lsr,
    input  logic [7:0] msr,
    input  logic [7:0] scr,
    output logic [7:0] rdata
);
    import uart_rf_pkg::*;

    always_comb begin
        unique case (addr)
            OFS_DATA: rdata = dlab ? dll : rbr;
            OFS_IER:  rdata = dlab ? dlh : {4'b0, ier};
            OFS_FIFO: rdata = iir;
            OFS_LCR:  rdata = lcr;
            OFS_MCR:  rdata = 8'h00;
            OFS_LSR:  rdata = lsr;
            OFS_MSR:  rdata = msr;
            default:  rdata = scr;
        endcase
    end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned LW    = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1,
    localparam int unsigned RXW   = 8 + ERR_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        tx_valid_o,
    output logic [7:0]  tx_data_o,
    input  logic        tx_pop,
    input  logic        tx_idle,
    input  logic        rx_push,
    input  logic [7:0]  rx_data,
    input  logic [2:0]  rx_err,
    input  logic [7:0]  msr_set,
    output logic [7:0]  lcr_o,
    output logic [3:0]  ier_o,
    output logic [4:0]  mcr_o,
    output logic [15:0] divisor_o,
    output logic        fifo_en_o,
    output logic [1:0]  rx_trig_o
);

    regs_t q, d;

    logic           dlab;
    logic           wr_thr, wr_dll, wr_dlh, wr_ier, wr_fcr, wr_lcr, wr_mcr, wr_scr;
    logic           rd_rbr, rd_lsr, rd_msr;
    logic           mode_chg, tx_clr, rx_clr, rx_drop;
    logic           tx_empty, tx_full, rx_empty, rx_full;
    logic [LW-1:0]  tx_level, rx_level;
    logic [7:0]     tx_head;
    logic [RXW-1:0] rx_head;
    logic [ERR_W-1:0] head_err;
    logic [7:0]     lsr_view, iir_view, rbr_view;

    // host strobe decode
    always_comb begin
        dlab   = q.lcr[7];
        wr_thr = wr_en & (addr == OFS_DATA) & ~dlab;
        wr_dll = wr_en & (addr == OFS_DATA) &  dlab;
        wr_dlh = wr_en & (addr == OFS_IER)  &  dlab;
        wr_ier = wr_en & (addr == OFS_IER)  & ~dlab;
        wr_fcr = wr_en & (addr == OFS_FIFO);
        wr_lcr = wr_en & (addr == OFS_LCR);
        wr_mcr = wr_en & (addr == OFS_MCR);
        wr_scr = wr_en & (addr == OFS_SCR);
        rd_rbr = rd_en & (addr == OFS_DATA) & ~dlab;
        rd_lsr = rd_en & (addr == OFS_LSR);
        rd_msr = rd_en & (addr == OFS_MSR);
        mode_chg = wr_fcr & (wdata[0] != q.fifo_en);
        tx_clr   = wr_fcr & (mode_chg | wdata[2]);
        rx_clr   = wr_fcr & (mode_chg | wdata[1]);
        rx_drop  = rx_push & rx_full & ~rd_rbr & ~rx_clr;
        head_err = rx_head[RXW-1:8];
    end

    uart_rf_fifo #(.W(8), .DEPTH(DEPTH), .KEEP_LO(8), .DROP_FULL(1'b0)) u_txq (
        .clk(clk), .rst_n(rst_n), .deep(q.fifo_en), .clr(tx_clr),
        .push(wr_thr), .pop(tx_pop), .scrub(1'b0), .din(wdata),
        .head(tx_head), .level(tx_level), .empty(tx_empty), .full(tx_full)
    );

    uart_rf_fifo #(.W(RXW), .DEPTH(DEPTH), .KEEP_LO(8), .DROP_FULL(1'b1)) u_rxq (
        .clk(clk), .rst_n(rst_n), .deep(q.fifo_en), .clr(rx_clr),
        .push(rx_push), .pop(rd_rbr), .scrub(1'b1),
        .din({|rx_err, rx_err, rx_data}),
        .head(rx_head), .level(rx_level), .empty(rx_empty), .full(rx_full)
    );

    // next-state of the register set
    always_comb begin
        d = q;
        if (wr_dll) d.dll = wdata;
        if (wr_dlh) d.dlh = wdata;
        if (wr_ier) d.ier = wdata[3:0];
        if (wr_lcr) d.lcr = wdata;
        if (wr_mcr) d.mcr = wdata[4:0];
        if (wr_scr) d.scr = wdata;
        if (wr_fcr) begin
            d.fifo_en = wdata[0];
            d.trig    = wdata[7:6];
        end
        // clear on read first, so flags arriving this cycle survive
        if (rd_lsr) begin
            d.err_oe  = 1'b0;
            d.err_pe  = 1'b0;
            d.err_fe  = 1'b0;
            d.err_bi  = 1'b0;
            d.err_sum = 1'b0;
        end
        if (rx_drop) begin
            d.err_oe  = 1'b1;
            d.err_sum = 1'b1;
        end
        if (!rx_empty) begin
            d.err_pe  = d.err_pe  | head_err[0];
            d.err_fe  = d.err_fe  | head_err[1];
            d.err_bi  = d.err_bi  | head_err[2];
            d.err_sum = d.err_sum | head_err[3];
        end
        if (rd_msr) d.msr = 8'h00;
        d.msr = d.msr | msr_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.lcr <= LCR_RESET;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        lsr_view = {q.err_sum, tx_empty & tx_idle, tx_empty, q.err_bi,
                    q.err_fe, q.err_pe, q.err_oe, ~rx_empty};
        iir_view = {q.fifo_en, q.fifo_en, 6'b000001};
        rbr_view = rx_empty ? 8'h00 : rx_head[7:0];
    end

    uart_rf_rdmux u_rdmux (
        .addr(addr), .dlab(dlab), .rbr(rbr_view), .dll(q.dll), .dlh(q.dlh),
        .ier(q.ier), .iir(iir_view), .lcr(q.lcr), .lsr(lsr_view),
        .msr(q.msr), .scr(q.scr), .rdata(rdata)
    );

    assign tx_valid_o = ~tx_empty;
    assign tx_data_o  = tx_head;
    assign lcr_o      = q.lcr;
    assign ier_o      = q.ier;
    assign mcr_o      = q.mcr;
    assign divisor_o  = {q.dlh, q.dll};
    assign fifo_en_o  = q.fifo_en;
    assign rx_trig_o  = q.trig;

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned LW    = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [7:0]    wdata,
    input logic          rx_push,
    input logic [7:0]    msr_set,
    input logic          tx_valid,
    input logic          fifo_en,
    input logic          dlab,
    input logic [15:0]   divisor,
    input logic          rx_full,
    input logic          rx_empty,
    input logic          tx_full,
    input logic [LW-1:0] rx_level,
    input logic [LW-1:0] tx_level,
    input logic [4:0]    err_bits,
    input logic [7:0]    msr_q
);

    logic [LW-1:0] lim;
    assign lim = fifo_en ? LW'(DEPTH) : LW'(1);

    p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= lim) && (tx_level <= lim) && (tx_full == (tx_level == lim)));

    p_dll_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && dlab) |=> (divisor[7:0] == $past(wdata)));

    p_thr_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && !dlab) |=> tx_valid);

    p_mode_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && wdata[0] != fifo_en) |=> (!tx_valid && rx_empty));

    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !(rd_en && addr == 3'd0) && !(wr_en && addr == 3'd2))
        |=> (err_bits[0] && err_bits[4] && !rx_empty));

    p_lsr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd5 && !rx_push && rx_empty) |=> (err_bits == 5'b0));

    p_msr_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd6 && msr_set == 8'h00) |=> (msr_q == 8'h00));

endmodule

bind uart_regfile uart_regfile_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rx_push(rx_push), .msr_set(msr_set),
    .tx_valid(tx_valid_o), .fifo_en(fifo_en_o), .dlab(lcr_o[7]),
    .divisor(divisor_o), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_full(tx_full), .rx_level(rx_level), .tx_level(tx_level),
    .err_bits({q.err_sum, q.err_bi, q.err_fe, q.err_pe, q.err_oe}),
    .msr_q(q.msr)
);

// File: tb/sim_uart_regfile.sv
module sim_uart_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        tx_valid_o;
    logic [7:0]  tx_data_o;
    logic        tx_pop = 1'b0, tx_idle = 1'b1;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [2:0]  rx_err = '0;
    logic [7:0]  msr_set = '0;
    logic [7:0]  lcr_o;
    logic [3:0]  ier_o;
    logic [4:0]  mcr_o;
    logic [15:0] divisor_o;
    logic        fifo_en_o;
    logic [1:0]  rx_trig_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] tq[$];
    logic [7:0] rq[$];
    logic [7:0] v;

    always #10 clk = ~clk;

    uart_regfile u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
        .tx_pop(tx_pop), .tx_idle(tx_idle), .rx_push(rx_push), .rx_data(rx_data),
        .rx_err(rx_err), .msr_set(msr_set), .lcr_o(lcr_o), .ier_o(ier_o),
        .mcr_o(mcr_o), .divisor_o(divisor_o), .fifo_en_o(fifo_en_o), .rx_trig_o(rx_trig_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] dt);
        @(negedge clk);
        addr = a; wdata = dt; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] dt);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 dt = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] got;
        rd(a, got);
        check(req, {8'h00, got}, {8'h00, exp});
    endtask

    task automatic push_rx(input logic [7:0] dt, input logic [2:0] e);
        @(negedge clk);
        rx_data = dt; rx_err = e; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; rx_err = '0;
    endtask

    task automatic pop_tx(input string req, input logic [7:0] exp);
        @(negedge clk);
        check(req, {7'b0, tx_valid_o, tx_data_o}, {8'h01, exp});
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 lcr", 3'd3, 8'h03);
        rd_chk("R1 lsr", 3'd5, 8'h60);
        rd_chk("R1 ier", 3'd1, 8'h00);
        rd_chk("R1 scr", 3'd7, 8'h00);
        rd_chk("R1 msr", 3'd6, 8'h00);
        rd_chk("R1 iir", 3'd2, 8'h01);
        check("R1 divisor", divisor_o, 16'h0000);

        // R3 masking
        wr(3'd1, 8'hFF); rd_chk("R3 ier mask", 3'd1, 8'h0F);
        wr(3'd4, 8'hFF); check("R3 mcr mask", {11'b0, mcr_o}, 16'h001F);
        rd_chk("R3 mcr reads zero", 3'd4, 8'h00);
        wr(3'd7, 8'hA5); rd_chk("R3 scr", 3'd7, 8'hA5);

        // R2 divisor access
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34); wr(3'd1, 8'h12);
        check("R2 divisor", divisor_o, 16'h1234);
        rd_chk("R2 dll", 3'd0, 8'h34);
        rd_chk("R2 dlh", 3'd1, 8'h12);
        check("R2 no tx push", {15'b0, tx_valid_o}, 16'h0);
        wr(3'd3, 8'h03);
        rd_chk("R2 ier kept", 3'd1, 8'h0F);

        // R4 R5 R6 single-entry mode
        wr(3'd0, 8'h11);
        check("R4 head", {7'b0, tx_valid_o, tx_data_o}, 16'h0111);
        rd_chk("R6 write clears", 3'd5, 8'h00);
        wr(3'd0, 8'h22);
        check("R5 overwrite depth1", {7'b0, tx_valid_o, tx_data_o}, 16'h0122);
        pop_tx("R4 pop", 8'h22);
        check("R4 empty", {15'b0, tx_valid_o}, 16'h0);
        rd_chk("R6 empty idle", 3'd5, 8'h60);
        tx_idle = 1'b0;
        rd_chk("R6 busy shifter", 3'd5, 8'h20);
        tx_idle = 1'b1;

        // R3 R4 R5 FIFO mode
        wr(3'd2, 8'h81);
        check("R3 fifo cfg", {13'b0, fifo_en_o, rx_trig_o}, 16'h0006);
        rd_chk("R3 iir fifo", 3'd2, 8'hC1);
        for (int i = 0; i < 16; i++) wr(3'd0, 8'h40 + 8'(i));
        wr(3'd0, 8'h99);
        pop_tx("R5 overwrite head", 8'h99);
        for (int i = 1; i < 16; i++) pop_tx("R4 order", 8'h40 + 8'(i));
        check("R5 level kept", {15'b0, tx_valid_o}, 16'h0);

        // R7 flush control
        wr(3'd0, 8'hA1); wr(3'd0, 8'hA2);
        push_rx(8'hB1, 3'b0); push_rx(8'hB2, 3'b0);
        wr(3'd2, 8'h01);
        check("R7 same mode keeps tx", {7'b0, tx_valid_o, tx_data_o}, 16'h01A1);
        rd_chk("R7 same mode keeps rx", 3'd5, 8'h01);
        wr(3'd2, 8'h05);
        check("R7 tx flush", {15'b0, tx_valid_o}, 16'h0);
        rd_chk("R7 rx kept", 3'd5, 8'h61);
        wr(3'd2, 8'h03);
        rd_chk("R7 rx flush", 3'd5, 8'h60);
        push_rx(8'hC1, 3'b0); wr(3'd0, 8'hC2);
        wr(3'd2, 8'h00);
        check("R7 mode flush tx", {15'b0, tx_valid_o}, 16'h0);
        rd_chk("R7 mode flush rx", 3'd5, 8'h60);
        rd_chk("R7 iir mode", 3'd2, 8'h01);

        // R8 R9 R11 single-entry receive
        rd_chk("R8 empty read", 3'd0, 8'h00);
        push_rx(8'h5A, 3'b0);
        rd_chk("R8 ready", 3'd5, 8'h61);
        rd_chk("R8 data", 3'd0, 8'h5A);
        rd_chk("R8 drained", 3'd5, 8'h60);
        push_rx(8'h01, 3'b0); push_rx(8'h02, 3'b0);
        rd_chk("R9 overrun", 3'd5, 8'hE3);
        rd_chk("R11 cleared", 3'd5, 8'h61);
        rd_chk("R9 kept first", 3'd0, 8'h01);
        wr(3'd5, 8'hFF);
        rd_chk("R11 write ignored", 3'd5, 8'h60);

        // R10 errors merge at head
        wr(3'd2, 8'h01);
        push_rx(8'h10, 3'b000);
        push_rx(8'h20, 3'b010);
        rd_chk("R10 not yet", 3'd5, 8'h61);
        rd_chk("R10 first", 3'd0, 8'h10);
        @(negedge clk);
        rd_chk("R10 merged", 3'd5, 8'hE9);
        rd_chk("R11 scrubbed", 3'd5, 8'h61);
        rd_chk("R10 data intact", 3'd0, 8'h20);
        rd_chk("R8 empty again", 3'd5, 8'h60);

        // R12 modem status
        @(negedge clk); msr_set = 8'h11;
        @(negedge clk); msr_set = 8'h00;
        rd_chk("R12 accumulate", 3'd6, 8'h11);
        rd_chk("R12 cleared", 3'd6, 8'h00);
        wr(3'd6, 8'hFF);
        rd_chk("R12 write ignored", 3'd6, 8'h00);

        // R4 R8 random traffic in FIFO mode
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 3));
            v = 8'($urandom);
            case (op)
                0: if (tq.size() < 16) begin wr(3'd0, v); tq.push_back(v); end
                1: if (tq.size() > 0) begin pop_tx("R4 random tx", tq[0]); void'(tq.pop_front()); end
                2: if (rq.size() < 16) begin push_rx(v, 3'b0); rq.push_back(v); end
                default: begin
                    if (rq.size() > 0) begin
                        rd_chk("R8 random rx", 3'd0, rq[0]);
                        void'(rq.pop_front());
                    end else begin
                        rd_chk("R8 random empty", 3'd0, 8'h00);
                    end
                end
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule